// File: doc/BRIEF.md
# Dual-Section Flash Read-While-Write Controller

This block manages access to a program flash that is split into two address sections. The lower section can be programmed while code keeps running from the upper section. The upper section holds the boot region and cannot be read while it is being programmed. The block accepts page erase and page write requests. It decides from the target page which section the operation hits. It then either blocks reads of the lower section or stalls the CPU fetch port for the whole operation.

The flash array is a behavioural memory that completes each operation after a fixed number of clock cycles. A status bit shows that the lower section is blocked. This bit stays set after the operation has finished, until software clears it while no operation is running. A read aimed at the blocked section returns all ones and raises a sticky access error flag. The boot page parameter is checked at elaboration to lie in the upper section.

Top module: `flash_rww_ctrl`

## Requirements
- R1: The section is picked only from the page index of the programming address. Pages below `RWW_PAGES` (page = address bits above the word offset) hit the lower section: `rww_busy_o` rises in the cycle after acceptance and `fetch_stall_o` stays 0. Pages at or above `RWW_PAGES` hit the upper section: `fetch_stall_o` rises in the cycle after acceptance.
- R2: While a lower-section page is being programmed, fetches of upper-section addresses are served normally and the fetch port is never stalled.
- R3: While an upper-section page is being programmed, `fetch_stall_o` is 1 for exactly `LATENCY` cycles, starting the cycle after acceptance. No fetch is accepted while it is 1.
- R4: `rww_busy_o` stays 1 after the lower-section operation completes. It returns to 0 only in the cycle after `busy_clr_i` is sampled high while no operation is in progress.
- R5: `busy_clr_i` has no effect while an operation is in progress. When it coincides with the acceptance of a new lower-section operation, the flag stays 1.
- R6: A fetch of a lower-section address while `rww_busy_o` is 1 returns all ones. It also sets `access_err_o`, which stays 1 until reset.
- R7: `prog_done_o` pulses for one cycle, `LATENCY`+1 cycles after the acceptance cycle. From then on the page reads back as all ones after an erase (`prog_erase_i`=1). After a write (`prog_erase_i`=0), word k of the page holds `prog_data_i[k*DATA_W +: DATA_W]`.
- R8: A programming request sampled while an operation is in progress is rejected. `prog_reject_o` pulses in the next cycle and the memory is left unchanged.
- R9: After reset, all outputs are 0 and every flash word reads all ones.
- R10: A fetch accepted in one cycle (`fetch_req_i`=1, `fetch_stall_o`=0) gives `fetch_valid_o`=1 and the addressed word on `fetch_data_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_i | input | 1 | Fetch/read request |
| fetch_addr_i | input | ADDR_W | Word address of the fetch |
| fetch_valid_o | output | 1 | Fetch data valid |
| fetch_data_o | output | DATA_W | Fetched word or all-ones filler |
| fetch_stall_o | output | 1 | CPU fetch halted |
| prog_req_i | input | 1 | Programming request |
| prog_erase_i | input | 1 | 1 = page erase, 0 = page write |
| prog_addr_i | input | ADDR_W | Address inside the target page |
| prog_data_i | input | PAGE_WORDS*DATA_W | Page contents for a write |
| prog_done_o | output | 1 | One-cycle completion pulse |
| prog_reject_o | output | 1 | One-cycle rejection pulse |
| busy_clr_i | input | 1 | Software clear of the busy flag |
| rww_busy_o | output | 1 | Lower section blocked |
| access_err_o | output | 1 | Sticky invalid-access flag |

## Verification
Two functions can fall on the same cycle: the software clear of the busy flag and the setting of that flag by a newly accepted lower-section operation. A second pair is a clear, a rejected request and an upper-section fetch, all issued in the first cycle of a running operation. The bench drives these inputs on the same clock edge. It then judges the result at the ports: the busy flag must read 1 in the following cycle, the reject pulse must appear, and the scoreboard must see the upper-section word.

// File: rtl/flash_rww_pkg.sv
package flash_rww_pkg;
  typedef enum logic {OP_WRITE = 1'b0, OP_ERASE = 1'b1} prog_op_e;
  typedef enum logic {SEC_RWW = 1'b0, SEC_NRWW = 1'b1} section_e;
endpackage

// File: rtl/flash_rww_seq.sv
module flash_rww_seq
  import flash_rww_pkg::*;
#(
  parameter int LATENCY   = 6,
  parameter int ADDR_W    = 6,
  parameter int OFS_W     = 2,
  parameter int RWW_PAGES = 10,
  parameter int PAGE_DW   = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  prog_op_e                op_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [PAGE_DW-1:0]      wdata_i,
  output logic                    active_o,
  output section_e                sec_o,
  output logic                    start_rww_o,
  output logic                    commit_o,
  output prog_op_e                cmt_op_o,
  output logic [ADDR_W-OFS_W-1:0] cmt_page_o,
  output logic [PAGE_DW-1:0]      cmt_data_o,
  output logic                    done_o,
  output logic                    reject_o
);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [PG_W-1:0] RWW_LIM = PG_W'(RWW_PAGES);

  logic             active_q, done_q, reject_q;
  logic [CNT_W-1:0] cnt_q;
  section_e         sec_q, in_sec;
  prog_op_e         op_q;
  logic [PG_W-1:0]  page_q;
  logic [PAGE_DW-1:0] data_q;
  logic             accept, finish;

  assign in_sec = (addr_i[ADDR_W-1:OFS_W] < RWW_LIM) ? SEC_RWW : SEC_NRWW;
  assign accept = req_i && !active_q;
  assign finish = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sec_q    <= SEC_RWW;
      op_q     <= OP_WRITE;
      page_q   <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      done_q   <= finish;
      reject_q <= req_i && active_q;
      if (accept) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(LATENCY - 1);
        sec_q    <= in_sec;
        op_q     <= op_i;
        page_q   <= addr_i[ADDR_W-1:OFS_W];
        data_q   <= wdata_i;
      end else if (finish) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign active_o    = active_q;
  assign sec_o       = sec_q;
  assign start_rww_o = accept && (in_sec == SEC_RWW);
  assign commit_o    = finish;
  assign cmt_op_o    = op_q;
  assign cmt_page_o  = page_q;
  assign cmt_data_o  = data_q;
  assign done_o      = done_q;
  assign reject_o    = reject_q;

  p_reject_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && req_i |=> reject_o);
  p_no_reject_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> !reject_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_op_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_q && $past(active_q));
endmodule

// File: rtl/flash_rww_array.sv
module flash_rww_array
  import flash_rww_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int NUM_PAGES  = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 commit_i,
  input  prog_op_e                             op_i,
  input  logic [$clog2(NUM_PAGES)-1:0]         page_i,
  input  logic [PAGE_WORDS*DATA_W-1:0]         pdata_i,
  input  logic                                 rd_en_i,
  input  logic [$clog2(NUM_PAGES*PAGE_WORDS)-1:0] rd_addr_i,
  input  logic                                 rd_block_i,
  output logic                                 rd_valid_o,
  output logic [DATA_W-1:0]                    rd_data_o
);
  localparam int OFS_W = $clog2(PAGE_WORDS);
  localparam int WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int ADDR_W = $clog2(WORDS);

  logic [DATA_W-1:0] mem_q [WORDS];
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      for (int k = 0; k < PAGE_WORDS; k++) begin
        mem_q[ADDR_W'({page_i, OFS_W'(k)})] <=
          (op_i == OP_ERASE) ? '1 : pdata_i[k*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_data_q <= rd_block_i ? '1 : mem_q[rd_addr_i];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  p_rd_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  p_filler_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_block_i |=> rd_data_o == '1);
endmodule

// File: rtl/flash_rww_ctrl.sv
module flash_rww_ctrl
  import flash_rww_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int NUM_PAGES  = 16,
  parameter int RWW_PAGES  = 10,
  parameter int BOOT_PAGE  = 12,
  parameter int LATENCY    = 6,
  localparam int ADDR_W    = $clog2(NUM_PAGES * PAGE_WORDS),
  localparam int PAGE_DW   = PAGE_WORDS * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_req_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  output logic               fetch_valid_o,
  output logic [DATA_W-1:0]  fetch_data_o,
  output logic               fetch_stall_o,
  input  logic               prog_req_i,
  input  logic               prog_erase_i,
  input  logic [ADDR_W-1:0]  prog_addr_i,
  input  logic [PAGE_DW-1:0] prog_data_i,
  output logic               prog_done_o,
  output logic               prog_reject_o,
  input  logic               busy_clr_i,
  output logic               rww_busy_o,
  output logic               access_err_o
);
  localparam int OFS_W = $clog2(PAGE_WORDS);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam logic [PG_W-1:0] RWW_LIM = PG_W'(RWW_PAGES);

  if (BOOT_PAGE < RWW_PAGES || BOOT_PAGE >= NUM_PAGES) begin : g_boot_check
    $error("boot page must lie in the upper section");
  end

  logic            op_active, start_rww, commit;
  section_e        op_sec;
  prog_op_e        cmt_op;
  logic [PG_W-1:0] cmt_page;
  logic [PAGE_DW-1:0] cmt_data;
  logic            busy_q, err_q, fetch_acc, fetch_blk;

  flash_rww_seq #(
    .LATENCY(LATENCY), .ADDR_W(ADDR_W), .OFS_W(OFS_W),
    .RWW_PAGES(RWW_PAGES), .PAGE_DW(PAGE_DW)
  ) u_seq (
    .clk_i, .rst_ni,
    .req_i      (prog_req_i),
    .op_i       (prog_erase_i ? OP_ERASE : OP_WRITE),
    .addr_i     (prog_addr_i),
    .wdata_i    (prog_data_i),
    .active_o   (op_active),
    .sec_o      (op_sec),
    .start_rww_o(start_rww),
    .commit_o   (commit),
    .cmt_op_o   (cmt_op),
    .cmt_page_o (cmt_page),
    .cmt_data_o (cmt_data),
    .done_o     (prog_done_o),
    .reject_o   (prog_reject_o)
  );

  assign fetch_stall_o = op_active && (op_sec == SEC_NRWW);
  assign fetch_acc     = fetch_req_i && !fetch_stall_o;
  assign fetch_blk     = busy_q && (fetch_addr_i[ADDR_W-1:OFS_W] < RWW_LIM);

  flash_rww_array #(
    .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)
  ) u_array (
    .clk_i, .rst_ni,
    .commit_i  (commit),
    .op_i      (cmt_op),
    .page_i    (cmt_page),
    .pdata_i   (cmt_data),
    .rd_en_i   (fetch_acc),
    .rd_addr_i (fetch_addr_i),
    .rd_block_i(fetch_blk),
    .rd_valid_o(fetch_valid_o),
    .rd_data_o (fetch_data_o)
  );

  // set on a new lower-section op wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (start_rww) busy_q <= 1'b1;
      else if (busy_clr_i && !op_active) busy_q <= 1'b0;
      if (fetch_acc && fetch_blk) err_q <= 1'b1;
    end
  end

  assign rww_busy_o   = busy_q;
  assign access_err_o = err_q;

  p_busy_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rww_busy_o && !busy_clr_i |=> rww_busy_o);
  p_clr_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_active && rww_busy_o |=> rww_busy_o);
  p_stall_no_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |=> !fetch_valid_o);
  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_err_o |=> access_err_o);
  p_err_filler_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(access_err_o) |-> fetch_valid_o && fetch_data_o == '1);
  p_sec_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_stall_o) |-> !$rose(rww_busy_o));
endmodule

// File: tb/flash_rww_ctrl_bench.sv
module flash_rww_ctrl_bench;
  localparam int DW = 16, PW = 4, NP = 16, RP = 10, LAT = 6;
  localparam int AW = $clog2(NP * PW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_req = 0, prog_req = 0, prog_erase = 0, busy_clr = 0;
  logic [AW-1:0] fetch_addr = '0, prog_addr = '0;
  logic [PW*DW-1:0] prog_data = '0;
  logic fetch_valid, fetch_stall, prog_done, prog_reject, rww_busy, access_err;
  logic [DW-1:0] fetch_data;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  flash_rww_ctrl #(.DATA_W(DW), .PAGE_WORDS(PW), .NUM_PAGES(NP), .RWW_PAGES(RP),
                   .BOOT_PAGE(12), .LATENCY(LAT)) u_flash_rww_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr), .fetch_valid_o(fetch_valid),
    .fetch_data_o(fetch_data), .fetch_stall_o(fetch_stall),
    .prog_req_i(prog_req), .prog_erase_i(prog_erase), .prog_addr_i(prog_addr),
    .prog_data_i(prog_data), .prog_done_o(prog_done), .prog_reject_o(prog_reject),
    .busy_clr_i(busy_clr), .rww_busy_o(rww_busy), .access_err_o(access_err));

  function automatic logic [AW-1:0] ad(int p, int k);
    return AW'(p * PW + k);
  endfunction

  function automatic logic [PW*DW-1:0] pdata(int p);
    logic [PW*DW-1:0] v;
    for (int k = 0; k < PW; k++) v[k*DW +: DW] = DW'(16'hA000 + p * 16 + k);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: pushes expected word, monitor pops it
  task automatic fetch(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    fetch_req = 1; fetch_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    step();
    fetch_req = 0;
  endtask

  task automatic issue(input int p, input bit erase, input bit clr);
    prog_req = 1; prog_erase = erase; prog_addr = ad(p, 1); prog_data = pdata(p);
    busy_clr = clr;
    step();
    prog_req = 0; busy_clr = 0;
  endtask

  // c: current cycle index after acceptance; done expected at LAT+1
  task automatic wait_done(input int c, input string req);
    while (!prog_done && c < 100) begin step(); c++; end
    chk(c == LAT + 1, req, 64'(c), 64'(LAT + 1));
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && fetch_valid) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected valid", 64'(fetch_data), 64'(0));
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(fetch_data === e, t, 64'(fetch_data), 64'(e));
      end
    end
  end

  initial begin
    #400000;
    chk(0, "watchdog", 64'(0), 64'(1));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c;
    repeat (3) step();
    // R9 reset state
    chk({fetch_valid, fetch_stall, prog_done, prog_reject, rww_busy, access_err} == 6'b0,
        "R9 reset outputs",
        64'({fetch_valid, fetch_stall, prog_done, prog_reject, rww_busy, access_err}), 64'(0));
    rst_n = 1;
    step();
    fetch(ad(0, 0), 16'hFFFF, "R9 erased after reset");
    fetch(ad(14, 3), 16'hFFFF, "R10 read upper word");

    // lower-section write of page 2, with clear, reject and upper fetch in cycle 1
    issue(2, 0, 0);
    chk(rww_busy == 1, "R1 lower page sets busy", 64'(rww_busy), 64'(1));
    chk(fetch_stall == 0, "R2 no stall", 64'(fetch_stall), 64'(0));
    fetch_req = 1; fetch_addr = ad(11, 0);
    exp_q.push_back(16'hFFFF); tag_q.push_back("R2 upper read served");
    prog_req = 1; prog_erase = 0; prog_addr = ad(5, 0); prog_data = pdata(5);
    busy_clr = 1;
    step();
    fetch_req = 0; prog_req = 0; busy_clr = 0;
    chk(prog_reject == 1, "R8 reject pulse", 64'(prog_reject), 64'(1));
    chk(rww_busy == 1, "R5 clear ignored while active", 64'(rww_busy), 64'(1));
    wait_done(2, "R7 done latency");
    step();
    chk(rww_busy == 1, "R4 busy sticky after done", 64'(rww_busy), 64'(1));
    fetch(ad(2, 1), 16'hFFFF, "R6 filler on blocked read");
    chk(access_err == 1, "R6 access error set", 64'(access_err), 64'(1));
    busy_clr = 1; step(); busy_clr = 0;
    chk(rww_busy == 0, "R4 clear when idle", 64'(rww_busy), 64'(0));
    fetch(ad(2, 1), 16'hA021, "R7 write data");
    fetch(ad(5, 0), 16'hFFFF, "R8 rejected write left page");

    // boundary: last lower page
    issue(RP - 1, 0, 0);
    chk(rww_busy == 1 && fetch_stall == 0, "R1 page RP-1 lower",
        64'({rww_busy, fetch_stall}), 64'(2'b10));
    wait_done(1, "R7 done latency page 9");
    fetch(ad(RP - 1, 3), 16'hFFFF, "R6 still blocked");

    // boundary: first upper page, fetch attempted through the stall
    issue(RP, 0, 0);
    chk(fetch_stall == 1, "R1 page RP upper", 64'(fetch_stall), 64'(1));
    c = 0;
    fetch_req = 1; fetch_addr = ad(3, 0);
    while (fetch_stall && c < 100) begin c++; step(); end
    fetch_req = 0;
    chk(c == LAT, "R3 stall length", 64'(c), 64'(LAT));
    chk(prog_done == 1, "R7 done after stall", 64'(prog_done), 64'(1));
    fetch(ad(RP, 2), 16'hA0A2, "R3 upper page written");

    // clear coinciding with a new lower-section op: erase page 2
    issue(2, 1, 1);
    chk(rww_busy == 1, "R5 set wins over clear", 64'(rww_busy), 64'(1));
    wait_done(1, "R7 erase latency");
    busy_clr = 1; step(); busy_clr = 0;
    chk(rww_busy == 0, "R4 clear after erase", 64'(rww_busy), 64'(0));
    fetch(ad(2, 1), 16'hFFFF, "R7 erased page");
    fetch(ad(RP - 1, 3), 16'hA093, "R7 page 9 data");
    chk(access_err == 1, "R6 error stays set", 64'(access_err), 64'(1));

    repeat (3) step();
    chk(exp_q.size() == 0, "R10 all fetches answered", 64'(exp_q.size()), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule